// File: doc/BRIEF.md
# Accumulator Arithmetic Unit

This block is a small arithmetic datapath built around one ripple-carry adder chain. The first adder operand is always the accumulator register. The second operand comes from a per-bit four-way selector. It can pick the external input word, its bitwise complement, all zeros or all ones. A carry-in bit completes the operation.

From these choices one adder gives addition, addition with carry, addition of the complement, two's-complement subtraction, increment, decrement and two forms of plain transfer. The sum and the carry-out are visible combinationally at all times. A load strobe writes both back on the next rising clock edge: the sum into the accumulator and the carry-out into a carry flag.

A controller sequences the operation through a 3-bit operation code and the load strobe. To seed the accumulator with a value, it resets the unit and then performs an addition with the load strobe high. The word width is a parameter and defaults to 4 bits.

Top module: `arith_accum_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, the accumulator and the carry flag both become 0 (synchronous reset).
- R2: Operation code bits [2:1] pick the second adder operand: 2'b00 selects `bIn`, 2'b01 selects `~bIn`, 2'b10 selects all zeros, 2'b11 selects all ones.
- R3: Operation code bit [0] is the carry-in of the least significant adder stage.
- R4: `sum` equals (accumulator + operand + carry-in) modulo 2^W, and `carryOut` is bit W of that full sum. With W=4, every code, accumulator value and `bIn` value follows this rule.
- R5: Code 3'b011 gives accumulator minus `bIn` in two's complement. `carryOut` is 1 exactly when accumulator >= `bIn` (no borrow).
- R6: Codes 3'b100 and 3'b111 both output the accumulator unchanged on `sum`. `carryOut` is 0 for 3'b100 and 1 for 3'b111.
- R7: When `loadEn` is high and `rst` is low at a rising edge, the accumulator takes `sum` and the carry flag takes `carryOut`.
- R8: When `loadEn` and `rst` are both low at a rising edge, the accumulator and the carry flag keep their values, whatever `bIn` and `ctrl` do.
- R9: When `rst` and `loadEn` are both high at an edge, reset wins and both registers become 0.
- R10: Increment (3'b101) of all ones gives 0 with `carryOut` 1. Decrement (3'b110) of 0 gives all ones with `carryOut` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bIn | input | W | External second operand |
| ctrl | input | 3 | Operation code: [2:1] operand select, [0] carry-in |
| loadEn | input | 1 | Write sum and carry-out back on the next edge |
| sum | output | W | Combinational adder result |
| carryOut | output | 1 | Carry out of the most significant stage |
| accOut | output | W | Accumulator register |
| carryFlag | output | 1 | Registered carry flag |

## Verification
The accumulator feeds the adder directly. A wrong accumulator value therefore shows on `sum` and `carryOut` combinationally, in the same cycle the register goes wrong. A wrong carry flag shows only on `carryFlag`, one edge after the faulty load. The bench seeds every accumulator value and sweeps every operation code against every `bIn` value. This exposes a swapped operand-select leg, a dropped carry-in or a broken carry link at once. The bench then checks one load per seed to confirm the written-back state.

// File: rtl/au_pkg.sv
package au_pkg;

  typedef enum logic [1:0] {
    OPD_B     = 2'b00,
    OPD_NOT_B = 2'b01,
    OPD_ZERO  = 2'b10,
    OPD_ONES  = 2'b11
  } operandSel_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    operandSel_e operandSel;
    logic        carryIn;
    logic        accWrite;
    logic        accClear;
  } auStrobes_t;

endpackage

// File: rtl/au_control.sv
module au_control
  import au_pkg::*;
(
  input  logic [2:0]  ctrl,
  input  logic        loadEn,
  input  logic        rst,
  output auStrobes_t  strobes
);

  always_comb begin
    strobes.operandSel = operandSel_e'(ctrl[2:1]);
    strobes.carryIn    = ctrl[0];
    // reset takes priority over a load in the same cycle
    strobes.accClear   = rst;
    strobes.accWrite   = loadEn & ~rst;
  end

endmodule

// File: rtl/au_operand_mux.sv
module au_operand_mux
  import au_pkg::*;
#(
  parameter int W = 4
) (
  input  operandSel_e   sel,
  input  logic [W-1:0]  bIn,
  output logic [W-1:0]  opnd
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (sel)
        OPD_B:     opnd[i] = bIn[i];
        OPD_NOT_B: opnd[i] = ~bIn[i];
        OPD_ZERO:  opnd[i] = 1'b0;
        default:   opnd[i] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/au_full_adder.sv
module au_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  logic halfSum;

  assign halfSum = x ^ y;
  assign s       = halfSum ^ ci;
  assign co      = (x & y) | (ci & halfSum);

endmodule

// File: rtl/au_ripple_adder.sv
module au_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);

  logic [W:0] carryChain;

  assign carryChain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    au_full_adder u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (carryChain[i]),
      .s  (s[i]),
      .co (carryChain[i+1])
    );
  end

  assign cout = carryChain[W];

endmodule

// File: rtl/au_datapath.sv
module au_datapath
  import au_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  auStrobes_t    strobes,
  input  logic [W-1:0]  bIn,
  output logic [W-1:0]  sum,
  output logic          carryOut,
  output logic [W-1:0]  accOut,
  output logic          carryFlag
);

  logic [W-1:0] accQ;
  logic         flagQ;
  logic [W-1:0] operand;

  au_operand_mux #(.W(W)) u_opmux (
    .sel  (strobes.operandSel),
    .bIn  (bIn),
    .opnd (operand)
  );

  au_ripple_adder #(.W(W)) u_adder (
    .x    (accQ),
    .y    (operand),
    .cin  (strobes.carryIn),
    .s    (sum),
    .cout (carryOut)
  );

  always_ff @(posedge clk) begin
    if (strobes.accClear) begin
      accQ  <= '0;
      flagQ <= 1'b0;
    end else if (strobes.accWrite) begin
      accQ  <= sum;
      flagQ <= carryOut;
    end
  end

  assign accOut    = accQ;
  assign carryFlag = flagQ;

endmodule

// File: rtl/arith_accum_unit.sv
module arith_accum_unit
  import au_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  bIn,
  input  logic [2:0]    ctrl,
  input  logic          loadEn,
  output logic [W-1:0]  sum,
  output logic          carryOut,
  output logic [W-1:0]  accOut,
  output logic          carryFlag
);

  auStrobes_t strobes;

  au_control u_ctrl (
    .ctrl    (ctrl),
    .loadEn  (loadEn),
    .rst     (rst),
    .strobes (strobes)
  );

  au_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .bIn       (bIn),
    .sum       (sum),
    .carryOut  (carryOut),
    .accOut    (accOut),
    .carryFlag (carryFlag)
  );

endmodule

// File: rtl/arith_accum_unit_chk.sv
module arith_accum_unit_chk #(
  parameter int W = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  bIn,
  input logic [2:0]    ctrl,
  input logic          loadEn,
  input logic [W-1:0]  sum,
  input logic          carryOut,
  input logic [W-1:0]  accOut,
  input logic          carryFlag
);

  // R1, R9: reset clears both registers, load or not
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (accOut == '0) && !carryFlag);

  // R7: load writes back sum and carry
  a_r7_load_captures: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (accOut == $past(sum)) && (carryFlag == $past(carryOut)));

  // R8: no load, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> $stable(accOut) && $stable(carryFlag));

  // R6: transfer codes pass the accumulator through
  a_r6_transfer_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 3'b100) |-> (sum == accOut) && !carryOut);

  a_r6_transfer_ones: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 3'b111) |-> (sum == accOut) && carryOut);

  // R10: increment of all ones wraps with carry
  a_r10_inc_wrap: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 3'b101 && accOut == {W{1'b1}}) |-> (sum == '0) && carryOut);

  // R5: subtracting a value from itself yields zero with no borrow
  a_r5_sub_self: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 3'b011 && bIn == accOut) |-> (sum == '0) && carryOut);

endmodule

bind arith_accum_unit arith_accum_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bIn       (bIn),
  .ctrl      (ctrl),
  .loadEn    (loadEn),
  .sum       (sum),
  .carryOut  (carryOut),
  .accOut    (accOut),
  .carryFlag (carryFlag)
);

// File: tb/arith_accum_unit_test.sv
module arith_accum_unit_test;

  localparam int W = 4;
  localparam int MAXV = (1 << W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  bIn = '0;
  logic [2:0]    ctrl = 3'b000;
  logic          loadEn = 1'b0;
  logic [W-1:0]  sum;
  logic          carryOut;
  logic [W-1:0]  accOut;
  logic          carryFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  arith_accum_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .bIn(bIn), .ctrl(ctrl), .loadEn(loadEn),
    .sum(sum), .carryOut(carryOut), .accOut(accOut), .carryFlag(carryFlag)
  );

  // Reference model from the requirements (R2, R3, R4)
  function automatic logic [W:0] refCalc(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic [2:0] code);
    logic [W-1:0] op;
    case (code[2:1])
      2'b00:   op = b;
      2'b01:   op = ~b;
      2'b10:   op = '0;
      default: op = '1;
    endcase
    return {1'b0, a} + {1'b0, op} + {{W{1'b0}}, code[0]};
  endfunction

  task automatic check(input string req, input logic [W:0] act,
                       input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Seed accumulator: reset, then add bIn with load
  task automatic seedAcc(input logic [W-1:0] a);
    @(negedge clk); rst = 1'b1; loadEn = 1'b0;
    @(negedge clk); rst = 1'b0; ctrl = 3'b000; bIn = a; loadEn = 1'b1;
    @(negedge clk); loadEn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk); rst = 1'b1; loadEn = 1'b1; ctrl = 3'b101; bIn = '1;
    @(negedge clk);
    check("R1 reset state", {carryFlag, accOut}, '0);
    rst = 1'b0;
    @(negedge clk);
    // load of acc+1 happened, then reset with load high again
    rst = 1'b1; loadEn = 1'b1; ctrl = 3'b111;
    @(negedge clk);
    check("R9 reset beats load", {carryFlag, accOut}, '0);
    rst = 1'b0; loadEn = 1'b0;
  endtask

  task automatic testAllCodes();
    for (int code = 0; code < 8; code++) begin
      for (int a = 0; a < MAXV; a++) begin
        seedAcc(W'(a));
        ctrl = 3'(code);
        for (int b = 0; b < MAXV; b++) begin
          bIn = W'(b);
          #1;
          check("R4 sweep (R2/R3 operand and carry-in)", {carryOut, sum},
                refCalc(W'(a), W'(b), 3'(code)));
        end
        bIn = W'(a ^ 5);
        loadEn = 1'b1;
        @(negedge clk);
        check("R7 load writes sum and carry", {carryFlag, accOut},
              refCalc(W'(a), W'(a ^ 5), 3'(code)));
        loadEn = 1'b0;
      end
    end
  endtask

  task automatic testSubtract();
    for (int a = 0; a < MAXV; a++) begin
      seedAcc(W'(a));
      ctrl = 3'b011;
      for (int b = 0; b < MAXV; b++) begin
        bIn = W'(b);
        #1;
        check("R5 subtract", {carryOut, sum},
              {(a >= b) ? 1'b1 : 1'b0, W'(a - b)});
      end
    end
  endtask

  task automatic testTransfer();
    seedAcc(W'(9));
    bIn = W'(6);
    ctrl = 3'b100; #1;
    check("R6 transfer code 100", {carryOut, sum}, {1'b0, W'(9)});
    ctrl = 3'b111; #1;
    check("R6 transfer code 111", {carryOut, sum}, {1'b1, W'(9)});
  endtask

  task automatic testHold();
    seedAcc(W'(11));
    ctrl = 3'b101; loadEn = 1'b1;
    @(negedge clk);   // acc = 12, flag 0
    loadEn = 1'b0;
    for (int i = 0; i < 6; i++) begin
      ctrl = 3'(i + 1); bIn = W'(i * 3);
      @(negedge clk);
      check("R8 hold without load", {carryFlag, accOut}, {1'b0, W'(12)});
    end
  endtask

  task automatic testWrap();
    seedAcc('1);
    ctrl = 3'b101; #1;
    check("R10 increment wrap", {carryOut, sum}, {1'b1, {W{1'b0}}});
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    check("R10 increment wrap loaded", {carryFlag, accOut}, {1'b1, {W{1'b0}}});
    ctrl = 3'b110; #1;
    check("R10 decrement wrap", {carryOut, sum}, {1'b0, {W{1'b1}}});
  endtask

  initial begin
    testReset();
    testAllCodes();
    testSubtract();
    testTransfer();
    testHold();
    testWrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule